// File: doc/BRIEF.md
# Processor Exception Priority Sequencer

This block decides which processor exception is taken, in which cycle, and in what order when several are raised together. Requests fall into three classes that differ in when they act. Hard faults (reset, bus error, address error) abort the running instruction and are taken at once. Boundary events (trace, interrupt, illegal opcode, privilege violation) wait until the current instruction has finished. Instruction traps (trap, trapv, check, zero divide) are raised by the executing instruction and rank below everything else.

The sequencer owns the trace and supervisor bits of the status register. It keeps the pre-exception copy of both bits for the stacking logic, and it tracks whether an exception frame is still open. A frame counts as open until the first handler instruction starts. Some exceptions are chained. A trace taken while an interrupt is requested is followed by that interrupt before any instruction runs. A trap raised with tracing on is followed by a trace. A hard fault that arrives while a frame is open halts the core until reset.

Top module: `exc_prio_seq`

## Requirements
- R1: A bus error or address error request, while not halted and with no frame open, produces `exc_take` and `exc_abort` in the first cycle after the request is sampled.
- R2: Hard faults are ranked reset over bus error over address error, with codes reset=1, bus error=2, address error=3. `req_reset` is always served, including while halted.
- R3: Boundary exceptions are taken only on a cycle with `insn_bnd` high, no frame open and no take in the previous cycle. They are ranked trace (taken when `sr_t` is 1, code 4), then interrupt (5), then illegal (6), then privilege (7).
- R4: A trap request is held until it can be taken. It gets code 8 plus `trap_kind` (0 trap, 1 trapv, 2 check, 3 zero divide). It yields to hard faults, to boundary exceptions and to chained exceptions.
- R5: A hard fault sampled together with a pending or new trap discards the trap, and that trap is never taken.
- R6: When trace is taken while `irq_req` is high, an interrupt (code 5) is taken two cycles later without any boundary strobe.
- R7: Every take sets `sr_s` to 1 and `sr_t` to 0, and places the prior values of those bits on `saved_s` and `saved_t`.
- R8: A trap taken with `sr_t` set is followed two cycles later by a trace exception (code 4), before the handler's first boundary.
- R9: A bus or address error while a frame is open sets `halt` and takes nothing. While halted, everything except `req_reset` is ignored, and a reset take clears `halt`.
- R10: `in_frame` rises with every take. It falls on an `insn_bnd` when no chained exception is due and no take happened in the previous cycle.
- R11: `exc_take` is a one-cycle pulse. A take is never directly followed by another take unless the second one is a reset.
- R12: After `rst_n`, the state is `sr_s`=1, `sr_t`=0, no take, no halt, no frame. `sr_load` copies `sr_t_in`/`sr_s_in` on any cycle that is not halted and takes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| req_reset | input | 1 | Reset exception request |
| req_buserr | input | 1 | Bus error request |
| req_addrerr | input | 1 | Address error request |
| insn_bnd | input | 1 | Instruction boundary strobe |
| irq_req | input | 1 | Interrupt request level |
| illegal_req | input | 1 | Next opcode is illegal |
| priv_req | input | 1 | Next opcode violates privilege |
| trap_req | input | 1 | Instruction trap raised this cycle |
| trap_kind | input | 2 | Trap kind: 0 trap, 1 trapv, 2 check, 3 zero divide |
| sr_load | input | 1 | Core writes trace/supervisor bits |
| sr_t_in | input | 1 | Trace bit value to load |
| sr_s_in | input | 1 | Supervisor bit value to load |
| exc_take | output | 1 | Exception taken (one-cycle pulse) |
| exc_code | output | 4 | Code of the exception taken |
| exc_abort | output | 1 | Abort the current instruction |
| halt | output | 1 | Core halted by a fault inside a frame |
| in_frame | output | 1 | Exception frame open |
| sr_t | output | 1 | Current trace bit |
| sr_s | output | 1 | Current supervisor bit |
| saved_t | output | 1 | Trace bit before the last take |
| saved_s | output | 1 | Supervisor bit before the last take |

## Verification
The assertions place no ordering rule on the request lines. Each property is conditioned on the block's own `halt` and `in_frame` outputs and on `req_reset`, so any input pattern is legal. The stimulus mixes sparse random pulses (faults and resets are rare, boundaries and levels are common) with directed sequences for the chained and halting cases. Reset is pulsed whenever the block is halted so that the random phase keeps exercising live arbitration.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
    localparam int CODE_W = 4;
    localparam int KIND_W = 2;
    localparam int G0_N   = 3;
    localparam int G1_N   = 4;

    typedef enum logic [CODE_W-1:0] {
        EXC_NONE    = 4'd0,
        EXC_RESET   = 4'd1,
        EXC_BUSERR  = 4'd2,
        EXC_ADDRERR = 4'd3,
        EXC_TRACE   = 4'd4,
        EXC_IRQ     = 4'd5,
        EXC_ILLEGAL = 4'd6,
        EXC_PRIV    = 4'd7,
        EXC_TRAP    = 4'd8,
        EXC_TRAPV   = 4'd9,
        EXC_CHK     = 4'd10,
        EXC_ZDIV    = 4'd11
    } exc_code_e;

    typedef struct packed {
        logic              take;
        logic              abort;
        exc_code_e         code;
        logic              halt;
        logic              in_frame;
        logic              t;
        logic              s;
        logic              sv_t;
        logic              sv_s;
        logic              trap_pend;
        logic [KIND_W-1:0] trap_kind;
        logic              trace_chain;
        logic              irq_chain;
    } seq_state_t;
endpackage

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);
    // lowest index wins
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    assign valid = |req;
endmodule

// File: rtl/exc_trap_merge.sv
module exc_trap_merge #(
    parameter int KW = 2
) (
    input  logic          pend_q,
    input  logic [KW-1:0] kind_q,
    input  logic          new_req,
    input  logic [KW-1:0] new_kind,
    output logic          pend_now,
    output logic [KW-1:0] kind_now
);
    assign pend_now = pend_q | new_req;
    assign kind_now = new_req ? new_kind : kind_q;
endmodule

// File: rtl/exc_prio_seq.sv
module exc_prio_seq
    import exc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_reset,
    input  logic              req_buserr,
    input  logic              req_addrerr,
    input  logic              insn_bnd,
    input  logic              irq_req,
    input  logic              illegal_req,
    input  logic              priv_req,
    input  logic              trap_req,
    input  logic [KIND_W-1:0] trap_kind,
    input  logic              sr_load,
    input  logic              sr_t_in,
    input  logic              sr_s_in,
    output logic              exc_take,
    output logic [CODE_W-1:0] exc_code,
    output logic              exc_abort,
    output logic              halt,
    output logic              in_frame,
    output logic              sr_t,
    output logic              sr_s,
    output logic              saved_t,
    output logic              saved_s
);
    localparam int G0_IW = $clog2(G0_N);
    localparam int G1_IW = $clog2(G1_N);

    seq_state_t q, d;

    logic             g0_valid, g1_valid;
    logic [G0_IW-1:0] g0_idx;
    logic [G1_IW-1:0] g1_idx;
    logic             tp_now;
    logic [KIND_W-1:0] tk_now;

    // hard faults: index 0 reset, 1 bus error, 2 address error
    exc_prio_pick #(.N(G0_N)) u_g0 (
        .req   ({req_addrerr, req_buserr, req_reset}),
        .valid (g0_valid),
        .idx   (g0_idx)
    );

    // boundary class: 0 trace, 1 interrupt, 2 illegal, 3 privilege
    exc_prio_pick #(.N(G1_N)) u_g1 (
        .req   ({priv_req, illegal_req, irq_req, q.t}),
        .valid (g1_valid),
        .idx   (g1_idx)
    );

    exc_trap_merge #(.KW(KIND_W)) u_trap (
        .pend_q   (q.trap_pend),
        .kind_q   (q.trap_kind),
        .new_req  (trap_req),
        .new_kind (trap_kind),
        .pend_now (tp_now),
        .kind_now (tk_now)
    );

    function automatic seq_state_t enter(seq_state_t cur, seq_state_t base, exc_code_e c);
        seq_state_t r;
        r          = base;
        r.take     = 1'b1;
        r.code     = c;
        r.sv_t     = cur.t;
        r.sv_s     = cur.s;
        r.t        = 1'b0;
        r.s        = 1'b1;
        r.in_frame = 1'b1;
        return r;
    endfunction

    always_comb begin
        d       = q;
        d.take  = 1'b0;
        d.abort = 1'b0;
        d.code  = EXC_NONE;
        if (g0_valid && g0_idx == '0) begin
            d             = enter(q, d, EXC_RESET);
            d.abort       = 1'b1;
            d.halt        = 1'b0;
            d.trap_pend   = 1'b0;
            d.trace_chain = 1'b0;
            d.irq_chain   = 1'b0;
        end else if (q.halt) begin
            // frozen until reset
        end else begin
            d.trap_pend = tp_now;
            d.trap_kind = tk_now;
            if (sr_load) begin
                d.t = sr_t_in;
                d.s = sr_s_in;
            end
            if (g0_valid) begin
                d.trap_pend   = 1'b0;
                d.trace_chain = 1'b0;
                d.irq_chain   = 1'b0;
                if (q.in_frame) begin
                    d.halt = 1'b1;
                end else begin
                    d       = enter(q, d, exc_code_e'(CODE_W'(g0_idx) + CODE_W'(1)));
                    d.abort = 1'b1;
                end
            end else if (!q.take) begin
                if (q.trace_chain) begin
                    d             = enter(q, d, EXC_TRACE);
                    d.trace_chain = 1'b0;
                    d.irq_chain   = irq_req;
                end else if (q.irq_chain) begin
                    d           = enter(q, d, EXC_IRQ);
                    d.irq_chain = 1'b0;
                end else if (insn_bnd && q.in_frame) begin
                    d.in_frame = 1'b0;
                end else if (insn_bnd && g1_valid) begin
                    d = enter(q, d, exc_code_e'(CODE_W'(g1_idx) + CODE_W'(4)));
                    if (g1_idx == '0) d.irq_chain = irq_req;
                end else if (tp_now) begin
                    d             = enter(q, d, exc_code_e'({2'b10, tk_now}));
                    d.trap_pend   = 1'b0;
                    d.trace_chain = q.t;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.code <= EXC_NONE;
            q.s    <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign exc_take  = q.take;
    assign exc_code  = q.code;
    assign exc_abort = q.abort;
    assign halt      = q.halt;
    assign in_frame  = q.in_frame;
    assign sr_t      = q.t;
    assign sr_s      = q.s;
    assign saved_t   = q.sv_t;
    assign saved_s   = q.sv_s;
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_reset,
    input logic       req_buserr,
    input logic       req_addrerr,
    input logic       exc_take,
    input logic [3:0] exc_code,
    input logic       exc_abort,
    input logic       halt,
    input logic       in_frame,
    input logic       sr_t,
    input logic       sr_s
);
    AST_FAULT_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_buserr || req_addrerr) && !req_reset && !halt && !in_frame |=> exc_take && exc_abort); // R1
    AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        req_reset |=> exc_take && exc_code == 4'd1 && !halt); // R2
    AST_ABORT_HARD: assert property (@(posedge clk) disable iff (!rst_n)
        exc_abort |-> exc_take && exc_code >= 4'd1 && exc_code <= 4'd3); // R2
    AST_TAKE_SUPER: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |-> sr_s && !sr_t); // R7
    AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_buserr || req_addrerr) && !req_reset && !halt && in_frame |=> halt && !exc_take); // R9
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halt && !req_reset |=> halt && !exc_take); // R9
    AST_FRAME_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |-> in_frame); // R10
    AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |=> !exc_take || exc_code == 4'd1); // R11
endmodule

bind exc_prio_seq exc_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_reset(req_reset), .req_buserr(req_buserr),
    .req_addrerr(req_addrerr), .exc_take(exc_take), .exc_code(exc_code),
    .exc_abort(exc_abort), .halt(halt), .in_frame(in_frame), .sr_t(sr_t), .sr_s(sr_s)
);

// File: tb/tb_exc_prio_seq.sv
module tb_exc_prio_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_reset = 0, req_buserr = 0, req_addrerr = 0, insn_bnd = 0;
    logic irq_req = 0, illegal_req = 0, priv_req = 0, trap_req = 0;
    logic [1:0] trap_kind = 0;
    logic sr_load = 0, sr_t_in = 0, sr_s_in = 0;
    logic exc_take, exc_abort, halt, in_frame, sr_t, sr_s, saved_t, saved_s;
    logic [3:0] exc_code;

    int errors = 0, checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    exc_prio_seq dut (.*);

    // expected-state model
    logic m_take, m_abort, m_halt, m_frame, m_t, m_s, m_svt, m_svs, m_tp, m_tc, m_ic;
    logic [3:0] m_code;
    logic [1:0] m_kind;

    task automatic model_reset();
        {m_take, m_abort, m_halt, m_frame, m_t, m_svt, m_svs, m_tp, m_tc, m_ic} = '0;
        m_s = 1; m_code = 0; m_kind = 0;
    endtask

    task automatic m_enter(input logic [3:0] c, input logic ot, input logic os);
        m_take = 1; m_code = c; m_svt = ot; m_svs = os; m_t = 0; m_s = 1; m_frame = 1;
    endtask

    task automatic model_step();
        logic ot, os, pt, tp_now;
        logic [1:0] k_now;
        ot = m_t; os = m_s; pt = m_take;
        tp_now = m_tp | trap_req;
        k_now = trap_req ? trap_kind : m_kind;
        m_take = 0; m_abort = 0; m_code = 0;
        if (req_reset) begin
            m_enter(4'd1, ot, os); m_abort = 1; m_halt = 0; m_tp = 0; m_tc = 0; m_ic = 0;
        end else if (!m_halt) begin
            m_tp = tp_now; m_kind = k_now;
            if (sr_load) begin m_t = sr_t_in; m_s = sr_s_in; end
            if (req_buserr || req_addrerr) begin
                m_tp = 0; m_tc = 0; m_ic = 0;
                if (m_frame) m_halt = 1;
                else begin m_enter(req_buserr ? 4'd2 : 4'd3, ot, os); m_abort = 1; end
            end else if (!pt) begin
                if (m_tc) begin m_enter(4'd4, ot, os); m_tc = 0; m_ic = irq_req; end
                else if (m_ic) begin m_enter(4'd5, ot, os); m_ic = 0; end
                else if (insn_bnd && m_frame) m_frame = 0;
                else if (insn_bnd && (ot || irq_req || illegal_req || priv_req)) begin
                    if (ot) begin m_enter(4'd4, ot, os); m_ic = irq_req; end
                    else if (irq_req) m_enter(4'd5, ot, os);
                    else if (illegal_req) m_enter(4'd6, ot, os);
                    else m_enter(4'd7, ot, os);
                end else if (tp_now) begin
                    m_enter({2'b10, k_now}, ot, os); m_tp = 0; m_tc = ot;
                end
            end
        end
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk("model", {3'b0, exc_take, exc_code, exc_abort, halt, in_frame, sr_t, sr_s, saved_t, saved_s},
            {3'b0, m_take, m_code, m_abort, m_halt, m_frame, m_t, m_s, m_svt, m_svs});
    endtask

    task automatic idle();
        {req_reset, req_buserr, req_addrerr, insn_bnd, irq_req, illegal_req, priv_req, trap_req, sr_load} = '0;
    endtask

    task automatic close_frame();
        idle(); insn_bnd = 1; tick(); idle();
    endtask

    initial begin
        #2000000;
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        chk("R12 reset", {exc_take, halt, in_frame, sr_s, sr_t}, 5'b00010);

        // R1 bus error, R11 pulse, R10 frame close
        req_buserr = 1; tick(); idle();
        chk("R1 fault take", {exc_take, exc_abort, exc_code}, {2'b11, 4'd2});
        tick();
        chk("R11 pulse", exc_take, 0);
        close_frame();
        chk("R10 frame clear", in_frame, 0);

        // R2 ordering
        req_buserr = 1; req_addrerr = 1; tick(); idle();
        chk("R2 bus>addr", exc_code, 4'd2);
        tick(); close_frame();
        req_reset = 1; req_buserr = 1; tick(); idle();
        chk("R2 reset>bus", exc_code, 4'd1);
        tick(); close_frame();

        // R3 boundary order
        insn_bnd = 1; irq_req = 1; illegal_req = 1; tick(); idle();
        chk("R3 irq>illegal", {exc_take, exc_code}, {1'b1, 4'd5});
        tick(); close_frame();
        insn_bnd = 1; illegal_req = 1; priv_req = 1; tick(); idle();
        chk("R3 illegal>priv", exc_code, 4'd6);
        tick(); close_frame();
        irq_req = 1; tick(); idle();
        chk("R3 needs boundary", exc_take, 0);

        // R4 trap code and ranking
        trap_req = 1; trap_kind = 2'd3; tick(); idle();
        chk("R4 zdiv code", {exc_take, exc_code}, {1'b1, 4'd11});
        tick(); close_frame();
        insn_bnd = 1; priv_req = 1; trap_req = 1; trap_kind = 2'd1; tick(); idle();
        chk("R4 priv first", exc_code, 4'd7);
        tick();
        chk("R4 gap", exc_take, 0);
        tick();
        chk("R4 trap held", {exc_take, exc_code}, {1'b1, 4'd9});
        tick(); close_frame();

        // R5 fault discards trap
        trap_req = 1; req_addrerr = 1; tick(); idle();
        chk("R5 fault wins", exc_code, 4'd3);
        tick(); close_frame(); tick(); tick();
        chk("R5 trap dropped", exc_take, 0);

        // R6, R7 trace then interrupt
        sr_load = 1; sr_t_in = 1; sr_s_in = 0; tick(); idle();
        chk("R12 sr load", {sr_t, sr_s}, 2'b10);
        insn_bnd = 1; irq_req = 1; tick(); idle();
        chk("R7 trace sr", {exc_take, exc_code, sr_t, sr_s, saved_t, saved_s}, {1'b1, 4'd4, 4'b0110});
        tick();
        chk("R6 gap", exc_take, 0);
        tick();
        chk("R6 chained irq", {exc_take, exc_code}, {1'b1, 4'd5});
        tick(); close_frame();

        // R8 trap with trace set
        sr_load = 1; sr_t_in = 1; sr_s_in = 0; tick(); idle();
        trap_req = 1; trap_kind = 2'd3; tick(); idle();
        chk("R8 zdiv", exc_code, 4'd11);
        tick(); tick();
        chk("R8 trace follows", {exc_take, exc_code, in_frame}, {1'b1, 4'd4, 1'b1});
        tick();

        // R9 double fault halts
        req_buserr = 1; tick(); idle();
        chk("R9 halt", {halt, exc_take}, 2'b10);
        insn_bnd = 1; irq_req = 1; sr_load = 1; sr_t_in = 1; tick(); idle();
        chk("R9 ignored", {halt, exc_take, sr_t}, 3'b100);
        req_reset = 1; tick(); idle();
        chk("R9 reset release", {halt, exc_take, exc_code}, {2'b01, 4'd1});
        tick(); close_frame();

        // random phase
        for (int i = 0; i < 3000; i++) begin
            idle();
            req_reset   = (halt && ($urandom % 4 == 0)) || ($urandom % 300 == 0);
            req_buserr  = ($urandom % 40 == 0);
            req_addrerr = ($urandom % 40 == 0);
            insn_bnd    = ($urandom % 3 == 0);
            irq_req     = ($urandom % 5 == 0);
            illegal_req = ($urandom % 12 == 0);
            priv_req    = ($urandom % 12 == 0);
            trap_req    = ($urandom % 15 == 0);
            trap_kind   = 2'($urandom);
            sr_load     = ($urandom % 10 == 0);
            sr_t_in     = ($urandom % 2 == 0);
            sr_s_in     = ($urandom % 2 == 0);
            tick();
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule